// File: doc/BRIEF.md
# Lockstep Bus Checker

Two processor cores run the same program in step, and this block watches their write traffic to confirm that they agree. It checks the cores in two identical lanes that run side by side. Each lane pairs the transactions of core A and core B in arrival order and compares address and data pair by pair. It also folds each core's data words into a 16-bit checksum and compares the two checksums when a window of transactions closes.

The lanes exchange their verdicts and checksum registers on every cycle. A difference between the lanes is treated as a fault in its own right. The health output is a heartbeat. It toggles once for every window that both lanes pass. Downstream logic should treat a heartbeat that stops moving as a fault. Any fault sets a sticky cause bit, drives the heartbeat low and holds it low until reset.

Top module: `lockstep_bus_checker`

## Requirements
- R1: Reset clears `fault_cause` to 0 and drives `heartbeat` to 0. `heartbeat` does not toggle until the first window after reset has passed.
- R2: The n-th transaction of core A is paired with the n-th transaction of core B. Either core may run ahead of the other, and up to QDEPTH (16) unpaired transactions per core are buffered.
- R3: If a pair differs in address or in data, `fault_cause` bit 0 is set. It is visible two cycles after the clock edge that samples the later transaction of the pair.
- R4: Each core's checksum is CRC-16 with polynomial 0x1021 and start value 0xFFFF. It takes 32 data bits per transaction, MSB first, and covers data only, not address. When the WIN_LEN-th (16th) pair of a window is accepted, the two checksums are compared and then restart at 0xFFFF. If they differ, `fault_cause` bit 1 is set.
- R5: A transaction that waits unpaired for TMO_LIM (8) cycles sets `fault_cause` bit 2. A partner that arrives 7 cycles later is accepted without fault.
- R6: Both lanes compute every verdict and checksum in the same cycle. Any difference between them sets `fault_cause` bit 3. A core mismatch is flagged by both lanes at once and therefore never sets bit 3.
- R7: If WDOG_LIM (64) consecutive cycles pass without a window pass, `fault_cause` bit 4 is set. A window pass that arrives in the 64th cycle prevents the expiry.
- R8: While no cause bit is set, `heartbeat` inverts two cycles after the clock edge that samples the last pair of a window that passes. It changes at no other time.
- R9: Cause bits are sticky until reset. While any cause bit is set, `heartbeat` is 0 and later passing windows do not toggle it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Core A write transaction strobe |
| a_addr | input | 32 | Core A write address |
| a_data | input | 32 | Core A write data |
| b_valid | input | 1 | Core B write transaction strobe |
| b_addr | input | 32 | Core B write address |
| b_data | input | 32 | Core B write data |
| heartbeat | output | 1 | Dynamic health signal; toggles per passed window, 0 when safe |
| fault_cause | output | 5 | Sticky causes: 0 pair mismatch, 1 checksum, 2 timeout, 3 lane disagreement, 4 watchdog |

## Verification
A window pass and a watchdog expiry can fall in the same cycle. A pass in the cycle where the counter reaches its limit must win, and a pass one cycle later must lose. The bench sends 15 pairs and then holds back the 16th pair. It releases that pair when the watchdog count in the reference model stands either two cycles or one cycle short of the edge at which the pass would arrive. In the first case the bench expects `fault_cause` to stay 0 and the heartbeat to toggle. In the second case it expects only bit 4 to be set, and it then confirms that a later good window leaves the heartbeat low.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
  localparam logic [CRC_W-1:0] CRC_INIT = 16'hFFFF;

  // fault cause bit positions
  localparam int CAUSE_W = 5;
  localparam int C_PAIR  = 0;
  localparam int C_CRC   = 1;
  localparam int C_TMO   = 2;
  localparam int C_LANE  = 3;
  localparam int C_WDOG  = 4;

  // per-lane verdict, registered once per cycle
  typedef struct packed {
    logic pass;
    logic pair_bad;
    logic crc_bad;
    logic tmo;
  } verdict_t;

endpackage

// File: rtl/txn_fifo.sv
module txn_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nonempty
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   cnt;
  logic          full, push_ok, pop_ok;

  assign full     = (cnt == FULL_CNT);
  assign nonempty = (cnt != '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && nonempty;
  assign dout     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst) !(push && full)); // R2
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst) pop |-> nonempty); // R2

endmodule

// File: rtl/check_lane.sv
module check_lane import lsc_pkg::*; #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int QDEPTH  = 16,
  parameter int WIN_LEN = 16,
  parameter int TMO_LIM = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a_valid,
  input  logic [AW-1:0]    a_addr,
  input  logic [DW-1:0]    a_data,
  input  logic             b_valid,
  input  logic [AW-1:0]    b_addr,
  input  logic [DW-1:0]    b_data,
  output verdict_t         verdict,
  output logic [CRC_W-1:0] crc_a_o,
  output logic [CRC_W-1:0] crc_b_o
);

  localparam int TW  = AW + DW;
  localparam int CW  = $clog2(WIN_LEN + 1);
  localparam int TCW = $clog2(TMO_LIM + 1);
  localparam logic [CW-1:0]  WIN_LAST = CW'(WIN_LEN - 1);
  localparam logic [TCW-1:0] TMO_LAST = TCW'(TMO_LIM - 1);

  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] seed,
                                                input logic [DW-1:0] w);
    logic [CRC_W-1:0] r;
    r = seed;
    for (int i = DW - 1; i >= 0; i--)
      r = {r[CRC_W-2:0], 1'b0} ^ ((r[CRC_W-1] ^ w[i]) ? CRC_POLY : '0);
    return r;
  endfunction

  logic [1:0]       in_valid;
  logic [TW-1:0]    in_word [2];
  logic [TW-1:0]    q_head  [2];
  logic [1:0]       q_ne;
  logic             pop, lone, close, pair_diff;
  logic [CRC_W-1:0] crc_q   [2];
  logic [CRC_W-1:0] crc_nx  [2];
  logic [CW-1:0]    win_cnt;
  logic             win_bad_q;
  logic [TCW-1:0]   tmo_cnt;

  assign in_valid   = {b_valid, a_valid};
  assign in_word[0] = {a_addr, a_data};
  assign in_word[1] = {b_addr, b_data};

  // one pairing queue per core
  generate
    for (genvar c = 0; c < 2; c++) begin : g_core
      txn_fifo #(.W(TW), .DEPTH(QDEPTH)) i_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (in_valid[c]),
        .din      (in_word[c]),
        .pop      (pop),
        .dout     (q_head[c]),
        .nonempty (q_ne[c])
      );
      assign crc_nx[c] = crc_fold(crc_q[c], q_head[c][DW-1:0]);
    end
  endgenerate

  assign pop       = &q_ne;
  assign lone      = ^q_ne;
  assign pair_diff = (q_head[0] != q_head[1]);
  assign close     = pop && (win_cnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q[0]  <= CRC_INIT;
      crc_q[1]  <= CRC_INIT;
      win_cnt   <= '0;
      win_bad_q <= 1'b0;
      tmo_cnt   <= '0;
      verdict   <= '0;
    end else begin
      verdict.pair_bad <= pop && pair_diff;
      verdict.crc_bad  <= close && (crc_nx[0] != crc_nx[1]);
      verdict.pass     <= close && (crc_nx[0] == crc_nx[1]) && !pair_diff && !win_bad_q;
      verdict.tmo      <= lone && (tmo_cnt == TMO_LAST);

      if (!lone)                    tmo_cnt <= '0;
      else if (tmo_cnt != TMO_LAST) tmo_cnt <= tmo_cnt + 1'b1;

      if (close) begin
        crc_q[0]  <= CRC_INIT;
        crc_q[1]  <= CRC_INIT;
        win_cnt   <= '0;
        win_bad_q <= 1'b0;
      end else if (pop) begin
        crc_q[0]  <= crc_nx[0];
        crc_q[1]  <= crc_nx[1];
        win_cnt   <= win_cnt + 1'b1;
        win_bad_q <= win_bad_q | pair_diff;
      end
    end
  end

  assign crc_a_o = crc_q[0];
  assign crc_b_o = crc_q[1];

  AST_CRC_REARM: assert property (@(posedge clk) disable iff (rst)
    close |=> (crc_q[0] == CRC_INIT && crc_q[1] == CRC_INIT)); // R4
  AST_TMO_AFTER_LONE: assert property (@(posedge clk) disable iff (rst)
    verdict.tmo |-> $past(lone)); // R5

endmodule

// File: rtl/lane_vote.sv
module lane_vote import lsc_pkg::*; (
  input  verdict_t         v0,
  input  verdict_t         v1,
  input  logic [CRC_W-1:0] crc_a0,
  input  logic [CRC_W-1:0] crc_b0,
  input  logic [CRC_W-1:0] crc_a1,
  input  logic [CRC_W-1:0] crc_b1,
  output verdict_t         merged,
  output logic             disagree
);

  // a pass needs both lanes; any flagged fault counts
  always_comb begin
    merged.pass     = v0.pass & v1.pass;
    merged.pair_bad = v0.pair_bad | v1.pair_bad;
    merged.crc_bad  = v0.crc_bad | v1.crc_bad;
    merged.tmo      = v0.tmo | v1.tmo;
    disagree        = (v0 != v1) || (crc_a0 != crc_a1) || (crc_b0 != crc_b1);
  end

endmodule

// File: rtl/heartbeat_gen.sv
module heartbeat_gen import lsc_pkg::*; #(
  parameter int WDOG_LIM = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  verdict_t           v,
  input  logic               disagree,
  output logic               heartbeat,
  output logic [CAUSE_W-1:0] fault_cause
);

  localparam int WCW = $clog2(WDOG_LIM + 1);
  localparam logic [WCW-1:0] WD_LAST = WCW'(WDOG_LIM - 1);

  logic [CAUSE_W-1:0] hit, cause_q, cause_nx;
  logic [WCW-1:0]     wd_q;
  logic               wd_exp, hb_q;

  assign wd_exp = !v.pass && (wd_q == WD_LAST);

  always_comb begin
    hit         = '0;
    hit[C_PAIR] = v.pair_bad;
    hit[C_CRC]  = v.crc_bad;
    hit[C_TMO]  = v.tmo;
    hit[C_LANE] = disagree;
    hit[C_WDOG] = wd_exp;
    cause_nx    = cause_q | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      wd_q    <= '0;
      hb_q    <= 1'b0;
    end else begin
      cause_q <= cause_nx;
      if (v.pass)       wd_q <= '0;
      else if (!wd_exp) wd_q <= wd_q + 1'b1;
      if (cause_nx != '0) hb_q <= 1'b0;
      else if (v.pass)    hb_q <= ~hb_q;
    end
  end

  assign heartbeat   = hb_q;
  assign fault_cause = cause_q;

  AST_SAFE_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
    (cause_q != '0) |-> !hb_q); // R9
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (($past(cause_q) & ~cause_q) == '0)); // R9
  AST_RISE_NEEDS_PASS: assert property (@(posedge clk) disable iff (rst)
    $rose(hb_q) |-> $past(v.pass)); // R8
  AST_WDOG_FIRES: assert property (@(posedge clk) disable iff (rst)
    (wd_q == WD_LAST && !v.pass) |=> cause_q[C_WDOG]); // R7

endmodule

// File: rtl/lockstep_bus_checker.sv
module lockstep_bus_checker import lsc_pkg::*; #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int QDEPTH   = 16,
  parameter int WIN_LEN  = 16,
  parameter int TMO_LIM  = 8,
  parameter int WDOG_LIM = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               a_valid,
  input  logic [AW-1:0]      a_addr,
  input  logic [DW-1:0]      a_data,
  input  logic               b_valid,
  input  logic [AW-1:0]      b_addr,
  input  logic [DW-1:0]      b_data,
  output logic               heartbeat,
  output logic [CAUSE_W-1:0] fault_cause
);

  localparam int LANES = 2;

  verdict_t         lane_v  [LANES];
  logic [CRC_W-1:0] lane_ca [LANES];
  logic [CRC_W-1:0] lane_cb [LANES];
  verdict_t         merged;
  logic             disagree;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      check_lane #(
        .AW(AW), .DW(DW), .QDEPTH(QDEPTH), .WIN_LEN(WIN_LEN), .TMO_LIM(TMO_LIM)
      ) i_lane (
        .clk     (clk),
        .rst     (rst),
        .a_valid (a_valid),
        .a_addr  (a_addr),
        .a_data  (a_data),
        .b_valid (b_valid),
        .b_addr  (b_addr),
        .b_data  (b_data),
        .verdict (lane_v[l]),
        .crc_a_o (lane_ca[l]),
        .crc_b_o (lane_cb[l])
      );
    end
  endgenerate

  lane_vote i_vote (
    .v0       (lane_v[0]),
    .v1       (lane_v[1]),
    .crc_a0   (lane_ca[0]),
    .crc_b0   (lane_cb[0]),
    .crc_a1   (lane_ca[1]),
    .crc_b1   (lane_cb[1]),
    .merged   (merged),
    .disagree (disagree)
  );

  heartbeat_gen #(.WDOG_LIM(WDOG_LIM)) i_hb (
    .clk         (clk),
    .rst         (rst),
    .v           (merged),
    .disagree    (disagree),
    .heartbeat   (heartbeat),
    .fault_cause (fault_cause)
  );

  AST_LANES_IN_STEP: assert property (@(posedge clk) disable iff (rst)
    (lane_v[0] == lane_v[1]) && (lane_ca[0] == lane_ca[1]) && (lane_cb[0] == lane_cb[1])); // R6

endmodule

// File: tb/test_lockstep_bus_checker.sv
module test_lockstep_bus_checker;

  localparam int WIN = 16;
  localparam int TMO = 8;
  localparam int WD  = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_valid = 1'b0, b_valid = 1'b0;
  logic [31:0] a_addr = '0, a_data = '0, b_addr = '0, b_data = '0;
  logic        heartbeat;
  logic [4:0]  fault_cause;

  int vectors = 0;
  int errors  = 0;
  int seq     = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  lockstep_bus_checker i_lockstep_bus_checker (
    .clk(clk), .rst(rst),
    .a_valid(a_valid), .a_addr(a_addr), .a_data(a_data),
    .b_valid(b_valid), .b_addr(b_addr), .b_data(b_data),
    .heartbeat(heartbeat), .fault_cause(fault_cause)
  );

  // ---------------- behavioural reference model ----------------
  logic [63:0] qa[$], qb[$];
  logic [63:0] ta, tb;
  logic [15:0] m_ca, m_cb;
  int          m_cnt, m_tc, m_wd;
  logic        m_bad, m_hb;
  logic [4:0]  m_cause, m_hit;
  logic        p_pass, p_pair, p_crc, p_tmo;

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ w[i];
      c  = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      qa.delete(); qb.delete();
      m_ca = 16'hFFFF; m_cb = 16'hFFFF;
      m_cnt = 0; m_tc = 0; m_wd = 0; m_bad = 0; m_hb = 0; m_cause = '0;
      p_pass = 0; p_pair = 0; p_crc = 0; p_tmo = 0;
    end else begin
      // decision stage, uses last cycle's lane verdicts
      m_hit = '0;
      m_hit[0] = p_pair;
      m_hit[1] = p_crc;
      m_hit[2] = p_tmo;
      if (p_pass) m_wd = 0;
      else if (m_wd == WD - 1) m_hit[4] = 1'b1;
      else m_wd++;
      m_cause = m_cause | m_hit;
      if (m_cause != '0) m_hb = 1'b0;
      else if (p_pass) m_hb = !m_hb;
      // lane stage
      p_pass = 0; p_pair = 0; p_crc = 0; p_tmo = 0;
      if (qa.size() > 0 && qb.size() > 0) begin
        ta = qa.pop_front();
        tb = qb.pop_front();
        p_pair = (ta != tb);
        m_bad  = m_bad | p_pair;
        m_ca   = ref_crc(m_ca, ta[31:0]);
        m_cb   = ref_crc(m_cb, tb[31:0]);
        m_cnt++;
        if (m_cnt == WIN) begin
          p_crc  = (m_ca != m_cb);
          p_pass = !p_crc && !m_bad;
          m_ca = 16'hFFFF; m_cb = 16'hFFFF; m_cnt = 0; m_bad = 0;
        end
        m_tc = 0;
      end else if ((qa.size() > 0) != (qb.size() > 0)) begin
        if (m_tc == TMO - 1) p_tmo = 1;
        else m_tc++;
      end else begin
        m_tc = 0;
      end
      if (a_valid) qa.push_back({a_addr, a_data});
      if (b_valid) qb.push_back({b_addr, b_data});
    end
  end

  // cycle-by-cycle compare against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      vectors++;
      if (heartbeat !== m_hb) begin
        errors++;
        $display("FAIL R8 heartbeat per-cycle: actual %0b expected %0b", heartbeat, m_hb);
      end
      vectors++;
      if (fault_cause !== m_cause) begin
        errors++;
        $display("FAIL R9 fault_cause per-cycle: actual %b expected %b", fault_cause, m_cause);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] word_of(int idx);
    return {32'h4000_0000 + 32'(idx) * 32'd4, (32'(idx) * 32'h9E37_79B1) ^ 32'h5A5A_0000};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; a_valid = 0; b_valid = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    seq = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n transactions per core; core A starts off_a cycles in, core B off_b
  task automatic run_window(input int n, input int off_a, input int off_b,
                            input int bad_idx, input bit bad_addr);
    int span;
    span = n + ((off_a > off_b) ? off_a : off_b);
    for (int t = 0; t < span; t++) begin
      @(negedge clk);
      a_valid = (t >= off_a) && (t - off_a < n);
      b_valid = (t >= off_b) && (t - off_b < n);
      {a_addr, a_data} = word_of(seq + t - off_a);
      {b_addr, b_data} = word_of(seq + t - off_b);
      if (b_valid && (t - off_b == bad_idx)) begin
        if (bad_addr) b_addr = b_addr ^ 32'h0000_0100;
        else          b_data = b_data ^ 32'h0000_0001;
      end
    end
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    seq += n;
  endtask

  task automatic one_pair();
    a_valid = 1; b_valid = 1;
    {a_addr, a_data} = word_of(seq);
    {b_addr, b_data} = word_of(seq);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    seq += 1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    do_reset();
    check("R1 heartbeat after reset", 32'(heartbeat), 0);
    check("R1 cause after reset", 32'(fault_cause), 0);

    run_window(WIN, 0, 0, -1, 0);
    check("R1 no toggle before window verdict", 32'(heartbeat), 0);
    idle(3);
    check("R8 toggle after first window", 32'(heartbeat), 1);

    run_window(WIN, 0, 3, -1, 0);             // A leads by 3
    idle(3);
    check("R2 skewed pairing, heartbeat", 32'(heartbeat), 0);

    run_window(WIN, 7, 0, -1, 0);             // B leads by 7
    idle(3);
    check("R5 lag of 7 accepted, heartbeat", 32'(heartbeat), 1);
    check("R5 lag of 7 accepted, cause", 32'(fault_cause), 0);

    // watchdog tie: pass arrives in the last allowed cycle
    run_window(WIN - 1, 0, 0, -1, 0);
    while (m_wd != WD - 3) @(negedge clk);
    one_pair();
    idle(4);
    check("R7 pass at limit rescues, cause", 32'(fault_cause), 0);
    check("R7 pass at limit rescues, heartbeat", 32'(heartbeat), 0);

    // one cycle too late: expiry
    run_window(WIN - 1, 0, 0, -1, 0);
    while (m_wd != WD - 2) @(negedge clk);
    one_pair();
    idle(4);
    check("R7 expiry sets bit 4", 32'(fault_cause), 32'h10);
    check("R9 heartbeat low after expiry", 32'(heartbeat), 0);

    run_window(WIN, 0, 0, -1, 0);
    idle(3);
    check("R9 later good window ignored, heartbeat", 32'(heartbeat), 0);
    check("R9 later good window ignored, cause", 32'(fault_cause), 32'h10);

    // data mismatch inside a window
    do_reset();
    check("R1 cause cleared by reset", 32'(fault_cause), 0);
    run_window(WIN, 0, 0, 5, 0);
    idle(3);
    check("R3 R4 data mismatch sets bits 0 and 1", 32'(fault_cause), 32'h03);
    check("R6 no lane disagreement on core mismatch", 32'(fault_cause[3]), 0);
    check("R9 heartbeat low after mismatch", 32'(heartbeat), 0);

    // timeout
    do_reset();
    run_window(WIN, 0, 0, -1, 0);
    idle(3);
    check("R8 toggle in timeout phase", 32'(heartbeat), 1);
    run_window(1, 0, TMO, -1, 0);
    idle(3);
    check("R5 lag of 8 times out", 32'(fault_cause), 32'h04);
    check("R9 heartbeat low after timeout", 32'(heartbeat), 0);

    // address-only mismatch on the last pair: checksum covers data only
    do_reset();
    run_window(WIN, 0, 0, WIN - 1, 1);
    idle(3);
    check("R3 R4 address mismatch, checksum unaffected", 32'(fault_cause), 32'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule